// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block turns single-byte requests from a host into strobe sequences for an external asynchronous static RAM of 2048 bytes. It drives active-low chip-select, output-enable and write-enable lines, an 11-bit address, and a data bus. The data bus is split into output, input and output-enable so that the pad ring can build the tri-state buffer. The host raises `req` together with `we`, `addr` and `wdata`. The controller takes the request only while it is idle. It runs the phase sequence for a read or a write and marks the end with a one-cycle `done` pulse. For reads, the byte appears on `rdata` at that point.

Each phase of the sequence lasts a whole number of clock cycles. That count is the ceiling of a nanosecond minimum from the memory's timing divided by the clock period, with a floor of one cycle. A write is framed by the overlap of the two strobes. Chip-select falls first and write-enable falls after it, so the write starts on write-enable. Write-enable then rises one hold cycle before chip-select, so the write also ends on write-enable. Output-enable stays high during the whole write. In a read, the byte is sampled on the last clock edge before chip-select and output-enable rise together. The bus is then kept idle until the memory's output drivers have released it.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: While `rst_n` is low, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe` and `done` are 0.
- R2: After a read is accepted, `sram_ce_n` and `sram_oe_n` are low and `sram_we_n` is high for exactly RD cycles, where RD = ceil(max(address access, select access, output-enable access) / clock period). This is 10 cycles at the defaults (100, 100, 50 ns, 10 ns clock).
- R3: `rdata` takes the value present on `sram_dq_i` at the last clock edge of the read strobe phase. It keeps that value until the next read captures a new one, and writes leave it unchanged.
- R4: In a write, `sram_ce_n` falls SU = max(1, ceil(address setup / period)) cycles before `sram_we_n` falls (1 at defaults). `sram_we_n` then stays low for WP = ceil(max(pulse width, data setup) / period) cycles (8 at defaults: 75 ns and 40 ns). It rises DH = 1 cycle before `sram_ce_n` rises, and `sram_oe_n` stays high for the whole write.
- R5: `sram_dq_oe` is 1 exactly while `sram_ce_n` is low during a write (SU+WP+DH = 10 cycles at defaults). It is never 1 during a read or while `sram_oe_n` is low. `sram_dq_o` carries the `wdata` accepted with the request and is stable the whole time it is driven.
- R6: `sram_a` is loaded from `addr` when a request is accepted and does not change while `sram_ce_n` is low. Changes to `addr` and `wdata` after acceptance have no effect.
- R7: A request is accepted only when the controller is idle. A `req` that arrives while an operation is in progress is dropped: it produces no strobe, no `done` and no memory write.
- R8: After a read, all strobes stay high for REL = ceil(output release / period) cycles before `done` (4 at defaults, 35 ns). After a write, they stay high for REC = max(1, ceil(write recovery / period)) cycles before `done` (1 at defaults).
- R9: `done` is high for exactly one cycle. It rises RD+REL clock edges after the accepting edge for a read (14) and SU+WP+DH+REC edges after it for a write (11). A request presented while `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, sampled when idle |
| we | input | 1 | 1 = write, 0 = read, sampled with req |
| addr | input | 11 | Byte address, sampled with req |
| wdata | input | 8 | Write byte, sampled with req |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_a | output | 11 | Memory address |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_i | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |

## Verification
The bench's memory model returns a junk byte until the full access time has passed. It also keeps driving the bus for the release time after a read. A controller that samples one edge too early therefore returns junk, and one that releases too soon shows bus contention on the next write. Write pulses shorter than WP, or data and addresses that move during the overlap, are refused by the model and counted. A wrong strobe order shows up in the first-fall and last-fall cycles the bench records per operation. A request injected in the middle of a write is checked to leave no trace, and so is a write cut short by reset. In that case the model keeps the old byte, and a design that let a partial write through would read back the new one.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_REL   = 3'd2,
    ST_WR_SU    = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5,
    ST_WR_REC   = 3'd6
  } sramc_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } sramc_strobe_t;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // strobe levels belonging to each phase
  function automatic sramc_strobe_t strobe_of(input sramc_state_e s);
    sramc_strobe_t r;
    r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    case (s)
      ST_RD_ACC:   begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
      ST_WR_SU:    begin r.ce_n = 1'b0; r.drive = 1'b1; end
      ST_WR_PULSE: begin r.ce_n = 1'b0; r.we_n = 1'b0; r.drive = 1'b1; end
      ST_WR_HOLD:  begin r.ce_n = 1'b0; r.drive = 1'b1; end
      default:     ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
`timescale 1ns/1ps
module sramc_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/sramc_fsm.sv
`timescale 1ns/1ps
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_LEN  = 10,
  parameter int REL_LEN = 4,
  parameter int SU_LEN  = 1,
  parameter int WP_LEN  = 8,
  parameter int DH_LEN  = 1,
  parameter int REC_LEN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             expire,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             done,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drive
);

  sramc_state_e  state_q, state_d;
  sramc_strobe_t strb_d;
  logic          finish;

  // phase length minus one, as loaded into the down-counter
  function automatic logic [CNT_W-1:0] len_of(input sramc_state_e s);
    int unsigned n;
    case (s)
      ST_RD_ACC:   n = RD_LEN;
      ST_RD_REL:   n = REL_LEN;
      ST_WR_SU:    n = SU_LEN;
      ST_WR_PULSE: n = WP_LEN;
      ST_WR_HOLD:  n = DH_LEN;
      ST_WR_REC:   n = REC_LEN;
      default:     n = 1;
    endcase
    return CNT_W'(n - 1);
  endfunction

  assign accept  = (state_q == ST_IDLE) && req;
  assign capture = (state_q == ST_RD_ACC) && expire;
  assign finish  = expire && ((state_q == ST_RD_REL) || (state_q == ST_WR_REC));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req) state_d = we ? ST_WR_SU : ST_RD_ACC;
      ST_RD_ACC:   if (expire) state_d = ST_RD_REL;
      ST_RD_REL:   if (expire) state_d = ST_IDLE;
      ST_WR_SU:    if (expire) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (expire) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (expire) state_d = ST_WR_REC;
      ST_WR_REC:   if (expire) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign load     = accept || (expire && (state_q != ST_IDLE));
  assign load_val = len_of(state_d);
  assign strb_d   = strobe_of(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      drive   <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= finish;
      ce_n    <= strb_d.ce_n;
      oe_n    <= strb_d.oe_n;
      we_n    <= strb_d.we_n;
      drive   <= strb_d.drive;
    end
  end

endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
module sramc_dpath #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_a,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_a  <= '0;
      dq_out <= '0;
    end else if (accept) begin
      mem_a  <= addr;
      dq_out <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= dq_in;
  end

endmodule

// File: rtl/sram_cyc_ctrl.sv
`timescale 1ns/1ps
module sram_cyc_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter int T_ACC_NS   = 100,
  parameter int T_CO_NS    = 100,
  parameter int T_OE_NS    = 50,
  parameter int T_OD_NS    = 35,
  parameter int T_AW_NS    = 0,
  parameter int T_WP_NS    = 75,
  parameter int T_DS_NS    = 40,
  parameter int T_WR_NS    = 10,
  parameter int T_DH_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_a,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe
);

  localparam int RD_CYC  = max2(ns_to_cyc(T_ACC_NS, CLK_NS),
                                max2(ns_to_cyc(T_CO_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int REL_CYC = ns_to_cyc(T_OD_NS, CLK_NS);
  localparam int SU_CYC  = ns_to_cyc(T_AW_NS, CLK_NS);
  localparam int WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int DH_CYC  = max2(T_DH_CYC, 1);
  localparam int REC_CYC = ns_to_cyc(T_WR_NS, CLK_NS);
  localparam int LEN_MAX = max2(max2(RD_CYC, REL_CYC), max2(max2(SU_CYC, WP_CYC), max2(DH_CYC, REC_CYC)));
  localparam int CNT_W   = $clog2(LEN_MAX) + 1;

  // named internal events for the checker
  logic             evt_accept;
  logic             evt_capture;
  logic             evt_expire;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [7:0]       wp_cycles_w;

  assign wp_cycles_w = 8'(WP_CYC);

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (evt_expire)
  );

  sramc_fsm #(
    .CNT_W   (CNT_W),
    .RD_LEN  (RD_CYC),
    .REL_LEN (REL_CYC),
    .SU_LEN  (SU_CYC),
    .WP_LEN  (WP_CYC),
    .DH_LEN  (DH_CYC),
    .REC_LEN (REC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .expire   (evt_expire),
    .load     (tmr_load),
    .load_val (tmr_val),
    .accept   (evt_accept),
    .capture  (evt_capture),
    .done     (done),
    .ce_n     (sram_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .drive    (sram_dq_oe)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (evt_accept),
    .capture (evt_capture),
    .addr    (addr),
    .wdata   (wdata),
    .dq_in   (sram_dq_i),
    .mem_a   (sram_a),
    .dq_out  (sram_dq_o),
    .rdata   (rdata)
  );

endmodule

// File: rtl/sram_cyc_ctrl_chk.sv
`timescale 1ns/1ps
module sram_cyc_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_a,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              done,
  input logic              evt_accept,
  input logic              evt_capture,
  input logic [7:0]        wp_cycles_w
);

  logic [7:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              we_low_cnt <= '0;
    else if (!sram_we_n)     we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1;
    else                     we_low_cnt <= '0;
  end

  p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  p_we_falls_after_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(!sram_ce_n));

  p_we_rises_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !sram_ce_n);

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt >= wp_cycles_w));

  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_ce_n));

  p_drive_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_a));

  p_capture_while_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |-> (!sram_oe_n && !sram_ce_n));

  p_oe_rises_after_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> sram_oe_n);

  p_accept_on_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |-> (sram_ce_n && sram_we_n && !sram_dq_oe));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sram_cyc_ctrl sram_cyc_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sram_ce_n   (sram_ce_n),
  .sram_oe_n   (sram_oe_n),
  .sram_we_n   (sram_we_n),
  .sram_dq_oe  (sram_dq_oe),
  .sram_a      (sram_a),
  .sram_dq_o   (sram_dq_o),
  .done        (done),
  .evt_accept  (evt_accept),
  .evt_capture (evt_capture),
  .wp_cycles_w (wp_cycles_w)
);

// File: tb/sram_cyc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_cyc_ctrl_tb_top;

  localparam int TCLK_NS = 10;
  // phase lengths restated from the requirements
  localparam int B_ACC = ((100 + TCLK_NS - 1) / TCLK_NS > (50 + TCLK_NS - 1) / TCLK_NS) ?
                         (100 + TCLK_NS - 1) / TCLK_NS : (50 + TCLK_NS - 1) / TCLK_NS;
  localparam int B_REL = (35 + TCLK_NS - 1) / TCLK_NS;
  localparam int B_SU  = 1;
  localparam int B_WP  = ((75 + TCLK_NS - 1) / TCLK_NS > (40 + TCLK_NS - 1) / TCLK_NS) ?
                         (75 + TCLK_NS - 1) / TCLK_NS : (40 + TCLK_NS - 1) / TCLK_NS;
  localparam int B_DH  = 1;
  localparam int B_REC = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [10:0] sram_a;
  logic [7:0]  sram_dq_o;
  logic [7:0]  dq_bus;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #(TCLK_NS/2) clk = ~clk;

  sram_cyc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_a(sram_a), .sram_dq_o(sram_dq_o),
    .sram_dq_i(dq_bus), .sram_dq_oe(sram_dq_oe)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [2048];
  logic        m_ovl, m_rd, m_drv, ovl_q;
  int          wcnt, acc_cnt, rel_cnt;
  int          viol_wr = 0;
  int          viol_bus = 0;
  logic [7:0]  wdat_m;
  logic [10:0] wadr_m;
  logic [7:0]  m_val;

  assign m_ovl  = !sram_ce_n && !sram_we_n;
  assign m_rd   = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign m_drv  = m_rd || (rel_cnt != 0);
  assign m_val  = (m_rd && acc_cnt >= B_ACC - 1) ? mem[sram_a] : 8'hEE;
  assign dq_bus = sram_dq_oe ? sram_dq_o : (m_drv ? m_val : 8'h00);

  always @(posedge clk) begin
    if (!rst_n) begin
      ovl_q <= 1'b0; wcnt <= 0; acc_cnt <= 0; rel_cnt <= 0;
      for (int i = 0; i < 2048; i++) mem[i] <= 8'h00;
    end else begin
      ovl_q <= m_ovl;
      if (m_ovl) begin
        wcnt <= wcnt + 1; wdat_m <= dq_bus; wadr_m <= sram_a;
        if (wcnt != 0 && (dq_bus != wdat_m || sram_a != wadr_m)) viol_wr <= viol_wr + 1;
      end else begin
        wcnt <= 0;
        if (ovl_q) begin
          if (wcnt >= B_WP) mem[wadr_m] <= wdat_m;
          else viol_wr <= viol_wr + 1;
        end
      end
      if (m_rd) begin acc_cnt <= acc_cnt + 1; rel_cnt <= B_REL; end
      else begin acc_cnt <= 0; if (rel_cnt != 0) rel_cnt <= rel_cnt - 1; end
      if (sram_dq_oe && m_drv) viol_bus <= viol_bus + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  logic [7:0] last_rd = 8'h00;

  // one operation; inj>0 raises a stray write request at that cycle index
  task automatic run_op(input logic w, input logic [10:0] a, input logic [7:0] d,
                        input logic [7:0] exp, input int inj);
    int ce_lo = 0, oe_lo = 0, we_lo = 0, drv = 0, dmis = 0, amis = 0;
    int ce_first = 0, we_first = 0, we_last = 0, ce_last = 0, done_k = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; addr = ~a; wdata = ~d;
    for (int k = 1; k <= 60; k++) begin
      if (done_k != 0) begin
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        break;
      end
      if (!sram_ce_n) begin
        ce_lo++; ce_last = k;
        if (ce_first == 0) ce_first = k;
        if (sram_a != a) amis++;
      end
      if (!sram_oe_n) oe_lo++;
      if (!sram_we_n) begin
        we_lo++; we_last = k;
        if (we_first == 0) we_first = k;
      end
      if (sram_dq_oe) begin
        drv++;
        if (sram_dq_o != d) dmis++;
      end
      if (done) done_k = k;
      if (inj != 0 && k == inj) begin req = 1'b1; we = 1'b1; addr = 11'h3C3; wdata = 8'h77; end
      if (inj != 0 && k == inj + 1) begin req = 1'b0; addr = ~a; wdata = ~d; end
      @(negedge clk);
    end
    chk(amis == 0, "R6 address held", amis, 0);
    chk(ce_first == 1, "R4/R2 select asserted after accept", ce_first, 1);
    if (!w) begin
      chk(ce_lo == B_ACC, "R2 select low cycles", ce_lo, B_ACC);
      chk(oe_lo == B_ACC, "R2 oe low cycles", oe_lo, B_ACC);
      chk(we_lo == 0, "R2 we stays high", we_lo, 0);
      chk(drv == 0, "R5 no drive on read", drv, 0);
      chk(done_k == B_ACC + B_REL + 1, "R8 read release then done", done_k, B_ACC + B_REL + 1);
      chk(rdata == exp, "R3 read data", rdata, exp);
      last_rd = exp;
    end else begin
      chk(we_first == 1 + B_SU, "R4 we falls after select", we_first, 1 + B_SU);
      chk(we_lo == B_WP, "R4 write pulse cycles", we_lo, B_WP);
      chk(ce_last == we_last + B_DH, "R4 we rises before select", ce_last, we_last + B_DH);
      chk(oe_lo == 0, "R4 oe high in write", oe_lo, 0);
      chk(drv == B_SU + B_WP + B_DH, "R5 drive window", drv, B_SU + B_WP + B_DH);
      chk(dmis == 0, "R5 driven data", dmis, 0);
      chk(done_k == B_SU + B_WP + B_DH + B_REC + 1, "R9 write done timing", done_k,
          B_SU + B_WP + B_DH + B_REC + 1);
      chk(rdata == last_rd, "R3 rdata kept across write", rdata, last_rd);
    end
    chk(viol_wr == 0, "R4 model write timing", viol_wr, 0);
    chk(viol_bus == 0, "R8 model bus contention", viol_bus, 0);
  endtask

  // we | addr | data (expected byte for reads)
  localparam logic [19:0] VECS [10] = '{
    {1'b1, 11'h000, 8'hA5},
    {1'b1, 11'h7FF, 8'h3C},
    {1'b1, 11'h155, 8'h5A},
    {1'b0, 11'h000, 8'hA5},
    {1'b0, 11'h7FF, 8'h3C},
    {1'b1, 11'h000, 8'hC3},
    {1'b0, 11'h000, 8'hC3},
    {1'b0, 11'h155, 8'h5A},
    {1'b1, 11'h2AA, 8'hFF},
    {1'b0, 11'h2AA, 8'hFF}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes idle in reset",
        {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    chk(!sram_dq_oe && !done, "R1 no drive, no done in reset", {sram_dq_oe, done}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++)
      run_op(VECS[v][19], VECS[v][18:8], VECS[v][7:0], VECS[v][7:0], 0);

    // R7: stray request during a write is dropped
    run_op(1'b1, 11'h0F0, 8'h4B, 8'h00, 4);
    begin
      int extra_ce = 0, extra_done = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (!sram_ce_n) extra_ce++;
        if (done) extra_done++;
      end
      chk(extra_ce == 0, "R7 no strobe from dropped req", extra_ce, 0);
      chk(extra_done == 0, "R7 no done from dropped req", extra_done, 0);
    end
    run_op(1'b0, 11'h3C3, 8'h00, 8'h00, 0);   // R7 dropped write left memory alone
    run_op(1'b0, 11'h0F0, 8'h4B, 8'h4B, 0);

    // R1: reset in the middle of a write pulse
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 11'h0AA; wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes released by reset",
        {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    chk(!sram_dq_oe && !done, "R1 bus released by reset", {sram_dq_oe, done}, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    last_rd = 8'h00;
    run_op(1'b0, 11'h0AA, 8'h00, 8'h00, 0);   // R1 aborted write not committed

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule